// File: doc/BRIEF.md
# GPIO Interrupt Route Aggregator

This block sits between the per-pin interrupt logic of a GPIO bank and the interrupt controller. Each pin controller reports a pending flag. The aggregator keeps eight programmable route masks for every port of the bank. For each route it forms a status word, which is the pending vector filtered by that route's mask. It also drives one interrupt line per route, which is the OR of that status word. A single lock register in the bank's security window can freeze the route masks, so that once trusted code has routed the pins, later code cannot re-steer them.

Software reaches the block through a single-cycle register port with a 12-bit byte address. The port windows start at `0x000` and are spaced `0x200` apart, one per port. The security window starts at `0x800`. Read data is registered, and a read can be issued on every cycle. The number of ports and the number of pins in each port are parameters, up to four ports of up to eight pins each. The defaults describe two ports: port 0 has 8 pins and port 1 has 5 pins.

Top module: `gpio_route_agg`

## Requirements
- R1: A synchronous reset clears every route mask and both lock bits, drives every route status word and route interrupt line low whatever the pending inputs are, and leaves the read data at zero.
- R2: While both lock bits are clear, a write to byte address `0x814 + p*0x20 + x*4` (port p, route x from 0 to 7) stores write-data bits [pins-1:0] into route mask x of port p. Mask bits at or above the port's pin count always read as zero. A read of the same address returns the stored mask.
- R3: Bit n of status word x of port p equals pending pin n of port p AND bit n of route mask x of port p. Status bits at or above the port's pin count are zero. `route_status` carries that bit at index `(p*8+x)*8+n`.
- R4: Route interrupt line x of port p (`route_irq` index `p*8+x`) is high exactly when status word x of port p has at least one bit set.
- R5: A read of byte address `p*0x200 + 0x100 + x*4` returns status word x of port p in bits [7:0], with the upper bits zero.
- R6: The security control register sits at `0x80C`. Writing 1 to bit 28 sets the write lock and writing 1 to bit 27 sets the read lock. Writing 0 to either bit leaves it unchanged, so only reset clears a lock. A read returns both lock bits in those positions and zero elsewhere.
- R7: While either lock bit is set, writes to the route mask addresses are ignored and every mask keeps its value.
- R8: Writing 1 to bit 0 of the security control register loads every route mask of every port with `(1 << pins) - 1`. This happens only if both lock bits were clear before that write, and a write that also sets a lock bit still loads the defaults. With a lock already set, the load is ignored. Bit 0 reads back as zero.
- R9: Read data appears on `reg_rdata` in the cycle after the read request and is zero in any cycle not following a read. Misaligned addresses, unused offsets and ports at or beyond the port count read as zero. Writes to status addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access request for this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_pending | input | NUM_PORTS*8 | Pending flags, port p at bits [p*8+7:p*8] |
| route_status | output | NUM_PORTS*64 | Status words, index (p*8+x)*8+n |
| route_irq | output | NUM_PORTS*8 | Route interrupt lines, index p*8+x |

## Verification
Several properties are checked on every cycle by the embedded assertions. The lock bits never fall outside reset. The masks hold still while any lock is set, and a default load fills every mask. No status bit is set without its pending pin, and no line fires with nothing pending. Read data is zero after non-read cycles. The address decoding, the exact status values for each pending pattern, and the ordering rule that lets a combined default-and-lock write still load the defaults can only be shown by the bench scenarios. The bench sweeps every port and route against masks and pending patterns that it computes itself.

// File: rtl/gpio_route_pkg.sv
package gpio_route_pkg;

    localparam int ROUTES     = 8;
    localparam int PINS_MAX   = 8;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int PORTS_MAX  = 4;

    localparam int LOCK_WR_BIT = 28;
    localparam int LOCK_RD_BIT = 27;
    localparam int DFLT_BIT    = 0;

    localparam logic [10:0] CTL_OFS  = 11'h00C;
    localparam logic [10:0] MASK_OFS = 11'h014;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CTL,
        ACC_MASK,
        ACC_STAT
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e   kind;
        logic [1:0]  port;
        logic [2:0]  route;
    } acc_dec_t;

    typedef logic [ROUTES-1:0][PINS_MAX-1:0] route_word_t;

    function automatic logic [PINS_MAX-1:0] pin_mask(input int pins);
        logic [PINS_MAX:0] t;
        t = (9'd1 << pins) - 9'd1;
        return t[PINS_MAX-1:0];
    endfunction

    // Map a byte address to the register it selects.
    function automatic acc_dec_t decode(input logic [ADDR_W-1:0] a, input int nports);
        acc_dec_t    d;
        logic [10:0] rel;
        d.kind  = ACC_NONE;
        d.port  = '0;
        d.route = '0;
        rel     = '0;
        if (a[1:0] == 2'b00) begin
            if (a[11]) begin
                if (a[10:0] == CTL_OFS) begin
                    d.kind = ACC_CTL;
                end else if (a[10:0] >= MASK_OFS) begin
                    rel = a[10:0] - MASK_OFS;
                    if (int'(rel[10:5]) < nports) begin
                        d.kind  = ACC_MASK;
                        d.port  = rel[6:5];
                        d.route = rel[4:2];
                    end
                end
            end else begin
                if (a[8:5] == 4'b1000 && int'(a[10:9]) < nports) begin
                    d.kind  = ACC_STAT;
                    d.port  = a[10:9];
                    d.route = a[4:2];
                end
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/route_lock_ctl.sv
module route_lock_ctl
    import gpio_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              lock_wr,
    output logic              lock_rd,
    output logic              masks_open,
    output logic              load_dflt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_wr <= 1'b0;
            lock_rd <= 1'b0;
        end else if (ctl_wr) begin
            lock_wr <= lock_wr | wdata[LOCK_WR_BIT];
            lock_rd <= lock_rd | wdata[LOCK_RD_BIT];
        end
    end

    always_comb begin
        masks_open = !lock_wr && !lock_rd;
        load_dflt  = ctl_wr && wdata[DFLT_BIT] && masks_open;
    end

    AST_LOCK_WR_STICKY: assert property (@(posedge clk) disable iff (rst)
        lock_wr |=> lock_wr); // R6
    AST_LOCK_RD_STICKY: assert property (@(posedge clk) disable iff (rst)
        lock_rd |=> lock_rd); // R6

endmodule

// File: rtl/route_mask_port.sv
module route_mask_port
    import gpio_route_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [2:0]          wr_route,
    input  logic [PINS_MAX-1:0] wr_data,
    input  logic                masks_open,
    input  logic                load_dflt,
    output route_word_t         masks
);

    localparam logic [PINS_MAX-1:0] KEEP = pin_mask(PINS);

    for (genvar r = 0; r < ROUTES; r++) begin : g_route
        always_ff @(posedge clk) begin
            if (rst) begin
                masks[r] <= '0;
            end else if (masks_open) begin
                if (load_dflt) begin
                    masks[r] <= KEEP;
                end else if (wr_en && wr_route == 3'(r)) begin
                    masks[r] <= wr_data & KEEP;
                end
            end
        end

        AST_MASK_UPPER: assert property (@(posedge clk) disable iff (rst)
            (masks[r] & ~KEEP) == '0); // R2
        AST_DFLT_FILL: assert property (@(posedge clk) disable iff (rst)
            load_dflt |=> masks[r] == KEEP); // R8
    end

    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !masks_open |=> $stable(masks)); // R7

endmodule

// File: rtl/route_status_port.sv
module route_status_port
    import gpio_route_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PINS_MAX-1:0] pending,
    input  route_word_t         masks,
    output route_word_t         status,
    output logic [ROUTES-1:0]   irq
);

    localparam logic [PINS_MAX-1:0] KEEP = pin_mask(PINS);

    always_comb begin
        for (int r = 0; r < ROUTES; r++) begin
            status[r] = pending & masks[r] & KEEP;
            irq[r]    = |status[r];
        end
    end

    for (genvar r = 0; r < ROUTES; r++) begin : g_chk
        AST_STAT_SUBSET: assert property (@(posedge clk) disable iff (rst)
            (status[r] & ~pending) == '0); // R3
        AST_STAT_UPPER: assert property (@(posedge clk) disable iff (rst)
            (status[r] & ~KEEP) == '0); // R3
    end

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pending & KEEP) == '0 |-> irq == '0); // R4

endmodule

// File: rtl/gpio_route_agg.sv
module gpio_route_agg
    import gpio_route_pkg::*;
#(
    parameter int                    NUM_PORTS = 2,
    parameter logic [NUM_PORTS*4-1:0] PORT_PINS = 8'h58
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             reg_en,
    input  logic                             reg_wr,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic [DATA_W-1:0]                reg_wdata,
    output logic [DATA_W-1:0]                reg_rdata,
    input  logic [NUM_PORTS*PINS_MAX-1:0]    pin_pending,
    output logic [NUM_PORTS*ROUTES*PINS_MAX-1:0] route_status,
    output logic [NUM_PORTS*ROUTES-1:0]      route_irq
);

    acc_dec_t    dec;
    logic        ctl_wr;
    logic        mask_wr;
    logic        rd_req;
    logic        lock_wr;
    logic        lock_rd;
    logic        masks_open;
    logic        load_dflt;

    route_word_t [NUM_PORTS-1:0]       mask_all;
    route_word_t [NUM_PORTS-1:0]       stat_all;
    logic [NUM_PORTS-1:0][ROUTES-1:0]  irq_all;

    always_comb begin
        dec     = decode(reg_addr, NUM_PORTS);
        ctl_wr  = reg_en && reg_wr && dec.kind == ACC_CTL;
        mask_wr = reg_en && reg_wr && dec.kind == ACC_MASK;
        rd_req  = reg_en && !reg_wr;
    end

    route_lock_ctl u_lock (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .wdata      (reg_wdata),
        .lock_wr    (lock_wr),
        .lock_rd    (lock_rd),
        .masks_open (masks_open),
        .load_dflt  (load_dflt)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam int PINS_P = int'(PORT_PINS[p*4 +: 4]);

        route_mask_port #(.PINS(PINS_P)) u_mask (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (mask_wr && dec.port == 2'(p)),
            .wr_route   (dec.route),
            .wr_data    (reg_wdata[PINS_MAX-1:0]),
            .masks_open (masks_open),
            .load_dflt  (load_dflt),
            .masks      (mask_all[p])
        );

        route_status_port #(.PINS(PINS_P)) u_stat (
            .clk     (clk),
            .rst     (rst),
            .pending (pin_pending[p*PINS_MAX +: PINS_MAX]),
            .masks   (mask_all[p]),
            .status  (stat_all[p]),
            .irq     (irq_all[p])
        );
    end

    assign route_status = stat_all;
    assign route_irq    = irq_all;

    always_ff @(posedge clk) begin
        if (rst || !rd_req) begin
            reg_rdata <= '0;
        end else begin
            unique case (dec.kind)
                ACC_CTL: begin
                    reg_rdata              <= '0;
                    reg_rdata[LOCK_WR_BIT] <= lock_wr;
                    reg_rdata[LOCK_RD_BIT] <= lock_rd;
                end
                ACC_MASK: reg_rdata <= DATA_W'(mask_all[dec.port][dec.route]);
                ACC_STAT: reg_rdata <= DATA_W'(stat_all[dec.port][dec.route]);
                default:  reg_rdata <= '0;
            endcase
        end
    end

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> reg_rdata == '0); // R9

endmodule

// File: tb/sim_gpio_route_agg.sv
module sim_gpio_route_agg;

    localparam int NP = 2;

    logic                clk = 1'b0;
    logic                rst;
    logic                reg_en;
    logic                reg_wr;
    logic [11:0]         reg_addr;
    logic [31:0]         reg_wdata;
    logic [31:0]         reg_rdata;
    logic [NP*8-1:0]     pin_pending;
    logic [NP*64-1:0]    route_status;
    logic [NP*8-1:0]     route_irq;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    gpio_route_agg #(.NUM_PORTS(NP), .PORT_PINS(8'h58)) u0 (
        .clk          (clk),
        .rst          (rst),
        .reg_en       (reg_en),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .pin_pending  (pin_pending),
        .route_status (route_status),
        .route_irq    (route_irq)
    );

    function automatic logic [7:0] keep_of(input int p);
        int pins;
        pins = (p == 0) ? 8 : 5;
        return 8'((16'd1 << pins) - 16'd1);
    endfunction

    function automatic logic [11:0] mask_addr(input int p, input int x);
        return 12'(32'h814 + p * 32'h20 + x * 4);
    endfunction

    function automatic logic [11:0] stat_addr(input int p, input int x);
        return 12'(p * 32'h200 + 32'h100 + x * 4);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic chk_all_masks(input string req, input logic [7:0] exp0, input logic [7:0] exp1);
        logic [31:0] d;
        for (int p = 0; p < NP; p++) begin
            for (int x = 0; x < 8; x++) begin
                rd(mask_addr(p, x), d);
                chk(req, d, {24'd0, (p == 0) ? exp0 : exp1});
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  m [NP][8];
        rst = 1'b1; reg_en = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        pin_pending = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: after reset everything is quiet even with all pins pending
        chk("R1 irq", 32'(route_irq), 32'd0);
        chk("R1 status", 32'(|route_status), 32'd0);
        chk("R1 rdata", reg_rdata, 32'd0);
        rd(12'h80C, d);
        chk("R1 ctl", d, 32'd0);
        chk_all_masks("R1 masks", 8'h00, 8'h00);

        // R2: per-route mask write and readback, upper bits dropped
        for (int p = 0; p < NP; p++) begin
            for (int x = 0; x < 8; x++) begin
                m[p][x] = 8'((p * 8 + x) * 37 + 11) & keep_of(p);
                wr(mask_addr(p, x), 32'hFFFF_FF00 | 32'(8'((p * 8 + x) * 37 + 11)));
            end
        end
        for (int p = 0; p < NP; p++) begin
            for (int x = 0; x < 8; x++) begin
                rd(mask_addr(p, x), d);
                chk("R2 mask readback", d, {24'd0, m[p][x]});
            end
        end

        // R3 R4 R5: sweep pending patterns
        for (int k = 0; k < 12; k++) begin
            logic [15:0] pend;
            pend = 16'((k * 16'h2D1B) ^ (k << 3) ^ 16'hA5C3);
            if (k == 0) pend = 16'h0000;
            if (k == 1) pend = 16'hFFFF;
            @(negedge clk);
            pin_pending = pend;
            #1;
            for (int p = 0; p < NP; p++) begin
                for (int x = 0; x < 8; x++) begin
                    logic [7:0] e;
                    e = pend[p*8 +: 8] & m[p][x] & keep_of(p);
                    chk("R3 status", 32'(route_status[(p*8+x)*8 +: 8]), 32'(e));
                    chk("R4 irq", 32'(route_irq[p*8+x]), 32'(|e));
                    rd(stat_addr(p, x), d);
                    chk("R5 status read", d, 32'(e));
                end
            end
        end

        // R9: unmapped reads and ignored status writes
        rd(12'h804, d);  chk("R9 unused", d, 32'd0);
        rd(12'h816, d);  chk("R9 misaligned", d, 32'd0);
        rd(12'h500, d);  chk("R9 absent port", d, 32'd0);
        rd(12'h854, d);  chk("R9 absent port mask", d, 32'd0);
        @(negedge clk); #1;
        chk("R9 idle rdata", reg_rdata, 32'd0);
        wr(stat_addr(0, 3), 32'h0000_0000);
        wr(stat_addr(1, 5), 32'hFFFF_FFFF);
        rd(mask_addr(0, 3), d); chk("R9 status write", d, 32'(m[0][3]));
        rd(mask_addr(1, 5), d); chk("R9 status write", d, 32'(m[1][5]));

        // R8: default load while unlocked
        wr(12'h80C, 32'h0000_0001);
        rd(12'h80C, d); chk("R8 bit0 reads zero", d, 32'd0);
        chk_all_masks("R8 defaults", keep_of(0), keep_of(1));
        wr(mask_addr(0, 2), 32'h0000_0000);
        rd(mask_addr(0, 2), d); chk("R2 rewrite", d, 32'd0);

        // R6 R7 R8: read lock set, sticky, blocks writes and defaults
        wr(12'h80C, 32'h0800_0000);
        rd(12'h80C, d); chk("R6 read lock", d, 32'h0800_0000);
        wr(12'h80C, 32'h0000_0000);
        rd(12'h80C, d); chk("R6 sticky", d, 32'h0800_0000);
        wr(mask_addr(0, 2), 32'h0000_00FF);
        rd(mask_addr(0, 2), d); chk("R7 locked write", d, 32'd0);
        wr(12'h80C, 32'h0000_0001);
        rd(mask_addr(0, 2), d); chk("R8 locked default", d, 32'd0);

        // R6 R1: reset clears lock; combined default-and-lock write
        do_reset();
        rd(12'h80C, d); chk("R6 reset clears", d, 32'd0);
        wr(12'h80C, 32'h1000_0001);
        rd(12'h80C, d); chk("R6 write lock", d, 32'h1000_0000);
        chk_all_masks("R8 load with lock", keep_of(0), keep_of(1));
        wr(mask_addr(1, 7), 32'h0000_0000);
        rd(mask_addr(1, 7), d); chk("R7 write lock", d, 32'(keep_of(1)));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule